// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block keeps calendar time in binary-coded decimal and exposes it as eight byte-wide registers. A prescaler outside the block supplies a one-cycle pulse once per second; each accepted pulse advances a carry chain. The chain runs from seconds through minutes, hours, weekday, day of month, month and year to a two-bit century counter. Month lengths and leap years are followed.

Two control bits share bytes with time fields: a stop flag beside the seconds and an interrupt-enable flag beside the minutes. Writing any time byte replaces that byte. It also pulses a clear to the external sub-second divider, so the new time starts a fresh second. The eighth byte holds a six-bit calibration word for a separate trimming block. Writing that byte touches neither the time nor the divider.

A byte pointer selects the register. It is loaded from the address pins and steps by one, wrapping from 7 to 0, after each read strobe or write. This supports single-byte and burst access. While `read_active` is high, second ticks do not change the time registers. A tick that arrives then is remembered and applied once the read ends.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the registers read 00 (seconds), 00 (minutes), 00 (hours), 01 (weekday), 01 (date), 01 (century 0, month 01), 00 (year), 00 (calibration). The stop and interrupt-enable flags are 0.
- R2: On each accepted tick, seconds count 00..59 in BCD. Seconds 59 wraps to 00 and carries into minutes, minutes 59 wraps to 00 and carries into hours, and hours 23 wraps to 00 (24-hour).
- R3: When hours wrap, the weekday (byte 3, bits 2:0) steps 7 to 1 or otherwise increments, and the date advances.
- R4: The date wraps to 01 and the month advances after day 31 in months 01, 03, 05, 07, 08, 10 and 12, after day 30 in months 04, 06, 09 and 11, and after day 28 in month 02. In a year divisible by 4 (year 00 included), month 02 wraps after day 29 instead.
- R5: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century field (byte 5, bits 7:6, modulo 4). The month sits in byte 5, bits 4:0.
- R6: While the stop flag (byte 0, bit 7) is 1, ticks are discarded and the time stays frozen. Once it is written 0, later ticks advance the time again.
- R7: A write to bytes 0 through 6 stores that byte and raises `divider_clear` in the same cycle. A write to byte 7 stores the calibration word (bits 5:0), leaves `divider_clear` low and leaves the time unchanged.
- R8: While `read_active` is 1 the time registers do not advance. A tick seen in that window is applied exactly once after `read_active` falls.
- R9: `addr_load` sets the pointer to `addr`. Each `rd_step` or `wr_en` cycle then moves the pointer up by one, wrapping from 7 to 0. `rd_data` shows the byte at the pointer.
- R10: Bits with no storage read 0: byte 2 bits 7:6, byte 3 bits 7:3, byte 4 bits 7:6, byte 5 bit 5 and byte 7 bits 7:6.
- R11: A tick in the same cycle as a time-byte write is discarded. The written value is what reads back afterwards.
- R12: The interrupt-enable flag (byte 1, bit 7) is stored on write, reads back and drives `intr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second from the prescaler |
| read_active | input | 1 | High while the front end is reading; holds time updates |
| addr_load | input | 1 | Load the byte pointer from `addr` |
| addr | input | 3 | Register index to load into the pointer |
| rd_step | input | 1 | Read strobe; advances the pointer after this cycle |
| wr_en | input | 1 | Write `wr_data` into the byte at the pointer, then advance |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Byte at the current pointer |
| divider_clear | output | 1 | Pulse that clears the external sub-second divider |
| intr_en | output | 1 | Stored interrupt-enable flag |
| cal_word | output | 6 | Stored calibration word for the trimming block |

## Verification
On every cycle, the assertions check the following. No advance occurs during a read or while stopped. The time stays put when neither a tick nor a write acts on it. Seconds wrap from 59 to 00. The pointer wraps from 7 to 0. A calibration write never disturbs the time. The bench scenarios are the only place to see the full carries: month lengths, leap February and the century step. The same goes for the deferred tick landing exactly once after a read, and a write beating a same-cycle tick. These need chosen register contents and are read back through the bus.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic       stop;
    logic [6:0] sec;
    logic       ie;
    logic [6:0] min;
    logic [5:0] hr;
    logic [2:0] dow;
    logic [5:0] date;
    logic [1:0] cent;
    logic [4:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [6:0] b;
    b = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  input  logic stop,
  input  logic wr_time,
  output logic advance
);
  logic pending_q;

  assign advance = !hold && !stop && !wr_time && (tick || pending_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pending_q <= 1'b0;
    else if (wr_time || stop) pending_q <= 1'b0;
    else if (hold)            pending_q <= pending_q | tick;
    else                      pending_q <= pending_q & tick;
  end

  a_r8_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !advance);
  a_r6_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !advance);

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output rtc_time_t        t
);
  rtc_time_t nx;
  logic c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] tmp_sec, tmp_min, tmp_hr, tmp_date, tmp_mon;

  always_comb begin
    nx = t;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    tmp_sec  = bcd_inc({1'b0, t.sec});
    tmp_min  = bcd_inc({1'b0, t.min});
    tmp_hr   = bcd_inc({2'b0, t.hr});
    tmp_date = bcd_inc({2'b0, t.date});
    tmp_mon  = bcd_inc({3'b0, t.mon});
    if (advance) begin
      if (t.sec == 7'h59) begin nx.sec = 7'h00; c_min = 1'b1; end
      else nx.sec = tmp_sec[6:0];
      if (c_min) begin
        if (t.min == 7'h59) begin nx.min = 7'h00; c_hr = 1'b1; end
        else nx.min = tmp_min[6:0];
      end
      if (c_hr) begin
        if (t.hr == 6'h23) begin nx.hr = 6'h00; c_day = 1'b1; end
        else nx.hr = tmp_hr[5:0];
      end
      if (c_day) begin
        nx.dow = (t.dow == 3'd7) ? 3'd1 : t.dow + 3'd1;
        if (t.date == last_day(t.mon, is_leap(t.yr))) begin nx.date = 6'h01; c_mon = 1'b1; end
        else nx.date = tmp_date[5:0];
      end
      if (c_mon) begin
        if (t.mon == 5'h12) begin nx.mon = 5'h01; c_yr = 1'b1; end
        else nx.mon = tmp_mon[4:0];
      end
      if (c_yr) begin
        if (t.yr == 8'h99) begin nx.yr = 8'h00; nx.cent = t.cent + 2'd1; end
        else nx.yr = bcd_inc(t.yr);
      end
    end
    if (wr_en) begin
      case (wr_idx)
        3'd0: begin nx.stop = wr_data[7]; nx.sec = wr_data[6:0]; end
        3'd1: begin nx.ie = wr_data[7];   nx.min = wr_data[6:0]; end
        3'd2: nx.hr   = wr_data[5:0];
        3'd3: nx.dow  = wr_data[2:0];
        3'd4: nx.date = wr_data[5:0];
        3'd5: begin nx.cent = wr_data[7:6]; nx.mon = wr_data[4:0]; end
        3'd6: nx.yr   = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t       <= '0;
      t.dow   <= 3'd1;
      t.date  <= 6'h01;
      t.mon   <= 5'h01;
    end else begin
      t <= nx;
    end
  end

  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !wr_en) |=> (t == $past(t)));
  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wr_en && t.sec == 7'h59) |=> (t.sec == 7'h00));

endmodule

// File: rtl/rtc_byte_ptr.sv
module rtc_byte_ptr #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (load)  ptr <= load_idx;
    else if (step)  ptr <= ptr + 1'b1;
  end

  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && ptr == LAST) |=> (ptr == '0));

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int CAL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1hz,
  input  logic             read_active,
  input  logic             addr_load,
  input  logic [IDX_W-1:0] addr,
  input  logic             rd_step,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             divider_clear,
  output logic             intr_en,
  output logic [CAL_W-1:0] cal_word
);
  localparam logic [IDX_W-1:0] CAL_IDX = IDX_W'(7);

  logic [IDX_W-1:0] ptr;
  logic             wr_time, advance;
  rtc_time_t        t;

  rtc_byte_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_idx(addr),
    .step(rd_step | wr_en), .ptr(ptr)
  );

  assign wr_time       = wr_en && (ptr != CAL_IDX);
  assign divider_clear = wr_time;

  rtc_tick_gate u_gate (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .hold(read_active),
    .stop(t.stop), .wr_time(wr_time), .advance(advance)
  );

  rtc_time_chain #(.IDX_W(IDX_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .advance(advance), .wr_en(wr_time),
    .wr_idx(ptr), .wr_data(wr_data), .t(t)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cal_word <= '0;
    else if (wr_en && ptr == CAL_IDX)      cal_word <= wr_data[CAL_W-1:0];
  end

  assign intr_en = t.ie;

  always_comb begin
    case (ptr)
      3'd0:    rd_data = {t.stop, t.sec};
      3'd1:    rd_data = {t.ie, t.min};
      3'd2:    rd_data = {2'b00, t.hr};
      3'd3:    rd_data = {5'b0, t.dow};
      3'd4:    rd_data = {2'b00, t.date};
      3'd5:    rd_data = {t.cent, 1'b0, t.mon};
      3'd6:    rd_data = t.yr;
      default: rd_data = 8'(cal_word);
    endcase
  end

  a_r7_cal_keeps_time: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == CAL_IDX && !advance) |=> (t == $past(t)));

endmodule

// File: tb/test_rtc_regfile.sv
module test_rtc_regfile;
  logic clk = 0, rst_n = 0;
  logic tick_1hz = 0, read_active = 0, addr_load = 0, rd_step = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic divider_clear, intr_en;
  logic [5:0] cal_word;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] q_exp[$];
  string q_tag[$];

  always #2 clk = ~clk;

  rtc_regfile i_rtc_regfile (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .read_active(read_active),
    .addr_load(addr_load), .addr(addr), .rd_step(rd_step), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .divider_clear(divider_clear),
    .intr_en(intr_en), .cal_word(cal_word)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each read strobe
  always @(negedge clk) begin
    if (rst_n && rd_step) begin
      if (q_exp.size() == 0) chk(0, "R9 unexpected read", rd_data, 8'hxx);
      else begin
        logic [7:0] e;
        string tg;
        e = q_exp.pop_front();
        tg = q_tag.pop_front();
        chk(rd_data === e, tg, rd_data, e);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tg);
    cyc(); addr_load = 1; addr = a;
    cyc(); addr_load = 0; wr_en = 1; wr_data = d;
    @(negedge clk);
    chk(divider_clear === (a != 3'd7), tg, {7'b0, divider_clear}, {7'b0, a != 3'd7});
    cyc(); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tg);
    cyc(); addr_load = 1; addr = a; read_active = 1;
    q_exp.push_back(e); q_tag.push_back(tg);
    cyc(); addr_load = 0; rd_step = 1;
    cyc(); rd_step = 0; read_active = 0;
  endtask

  task automatic tick();
    cyc(); tick_1hz = 1;
    cyc(); tick_1hz = 0;
  endtask

  task automatic set_eod(input logic [7:0] date, input logic [7:0] mon, input logic [7:0] yr);
    wr(3'd2, 8'h23, "R7 wr hr"); wr(3'd1, 8'h59, "R7 wr min"); wr(3'd0, 8'h59, "R7 wr sec");
    wr(3'd4, date, "R7 wr date"); wr(3'd5, mon, "R7 wr mon"); wr(3'd6, yr, "R7 wr yr");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rst_exp [9];
    rst_exp = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    repeat (3) cyc();
    rst_n = 1;
    // R1 reset contents by burst, R9 wrap to byte 0 on the ninth strobe
    cyc(); addr_load = 1; addr = 0; read_active = 1;
    for (int i = 0; i < 9; i++) begin
      q_exp.push_back(rst_exp[i]);
      q_tag.push_back(i == 8 ? "R9 burst wrap" : "R1 reset byte");
    end
    cyc(); addr_load = 0; rd_step = 1;
    repeat (9) cyc();
    rd_step = 0; read_active = 0;
    chk(intr_en === 1'b0, "R1 intr_en", {7'b0, intr_en}, 8'h00);

    // R2 seconds, minutes, hours carries
    wr(3'd0, 8'h58, "R7 wr sec");
    tick(); rd(3'd0, 8'h59, "R2 sec inc");
    tick(); rd(3'd0, 8'h00, "R2 sec wrap"); rd(3'd1, 8'h01, "R2 min carry");
    wr(3'd1, 8'h59, "R7 wr min"); wr(3'd0, 8'h59, "R7 wr sec");
    tick(); rd(3'd1, 8'h00, "R2 min wrap"); rd(3'd2, 8'h01, "R2 hr carry");

    // R3/R4 end of February in a non-leap year, weekday 7 -> 1
    wr(3'd3, 8'h07, "R7 wr dow");
    set_eod(8'h28, 8'h02, 8'h23);
    tick();
    rd(3'd2, 8'h00, "R2 hr wrap"); rd(3'd3, 8'h01, "R3 dow wrap");
    rd(3'd4, 8'h01, "R4 feb28 wrap"); rd(3'd5, 8'h03, "R4 month after feb");

    // R4 leap year: 28 -> 29, then 29 -> 01 March
    set_eod(8'h28, 8'h02, 8'h24);
    tick(); rd(3'd4, 8'h29, "R4 leap 29"); rd(3'd3, 8'h02, "R3 dow inc");
    set_eod(8'h29, 8'h02, 8'h24);
    tick(); rd(3'd4, 8'h01, "R4 leap wrap"); rd(3'd5, 8'h03, "R4 leap month");

    // R4 thirty-day month
    set_eod(8'h30, 8'h04, 8'h24);
    tick(); rd(3'd4, 8'h01, "R4 apr30 wrap"); rd(3'd5, 8'h05, "R4 month inc");

    // R5 year and century carry: century 1, Dec 31 99
    set_eod(8'h31, 8'h52, 8'h99);
    tick(); rd(3'd5, 8'h81, "R5 century+month"); rd(3'd6, 8'h00, "R5 year wrap");

    // R6 stop flag
    wr(3'd0, 8'h90, "R7 wr stop");
    tick(); rd(3'd0, 8'h90, "R6 stopped");
    wr(3'd0, 8'h10, "R7 wr run");
    tick(); rd(3'd0, 8'h11, "R6 resumed");

    // R7 calibration write, R10 unused bits
    wr(3'd7, 8'hFF, "R7 cal no divider_clear");
    rd(3'd7, 8'h3F, "R10 cal upper bits");
    rd(3'd0, 8'h11, "R7 time kept");
    chk(cal_word === 6'h3F, "R7 cal_word", {2'b0, cal_word}, 8'h3F);
    wr(3'd3, 8'hFF, "R7 wr dow");
    rd(3'd3, 8'h07, "R10 dow upper bits");
    wr(3'd5, 8'h3F, "R7 wr mon");
    rd(3'd5, 8'h1F, "R10 month bit5");

    // R8 tick during a read is deferred, applied once
    wr(3'd0, 8'h30, "R7 wr sec");
    cyc(); read_active = 1; addr_load = 1; addr = 0;
    cyc(); addr_load = 0; tick_1hz = 1;
    cyc(); tick_1hz = 0; rd_step = 1;
    q_exp.push_back(8'h30); q_tag.push_back("R8 held during read");
    cyc(); rd_step = 0; read_active = 0;
    repeat (4) cyc();
    rd(3'd0, 8'h31, "R8 deferred tick applied");
    repeat (4) cyc();
    rd(3'd0, 8'h31, "R8 applied only once");

    // R11 write beats same-cycle tick
    cyc(); addr_load = 1; addr = 0;
    cyc(); addr_load = 0; wr_en = 1; wr_data = 8'h20; tick_1hz = 1;
    cyc(); wr_en = 0; tick_1hz = 0;
    rd(3'd0, 8'h20, "R11 write wins");
    repeat (4) cyc();
    rd(3'd0, 8'h20, "R11 tick discarded");

    // R12 interrupt-enable flag
    wr(3'd1, 8'h85, "R7 wr ie");
    @(negedge clk);
    chk(intr_en === 1'b1, "R12 intr_en set", {7'b0, intr_en}, 8'h01);
    rd(3'd1, 8'h85, "R12 ie readback");
    wr(3'd1, 8'h05, "R7 wr ie clear");
    @(negedge clk);
    chk(intr_en === 1'b0, "R12 intr_en clear", {7'b0, intr_en}, 8'h00);

    repeat (3) cyc();
    chk(q_exp.size() == 0, "R9 scoreboard drained", 8'(q_exp.size()), 8'h00);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule